// File: doc/BRIEF.md
# Indexed Color Scanout Engine

This block turns a frame of 8-bit palette indices held in linear video memory into a stream of true-colour pixels. On a start request it walks the frame in row-major order, issuing one byte read per cycle. Each returned byte is sent unchanged as the address of a 256-entry colour lookup, and the three returned 8-bit components are packed into a 32-bit pixel word. Start-of-row and end-of-frame markers travel with each pixel through the read pipeline, so they stay aligned with the colour they describe.

When a frame has been fully emitted, the engine raises a one-cycle completion pulse. If the vertical-sync interrupt is enabled, that pulse sets a sticky interrupt flag, which stays set until it is cleared. Any palette update, and reset itself, marks the next frame as one that must be redrawn in full. A display controller can read that mark alongside the frame. Frame width and height are parameters. The memory and palette read latencies are parameters as well, both one cycle by default.

Top module: `ics_scanout`

## Requirements
- R1: Every byte returned from video memory is presented unchanged as the palette index, with the palette read strobe active, in the cycle after that byte's memory read strobe.
- R2: Each output pixel word carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0, all taken from the palette entry, and bits 31:24 are always zero.
- R3: Within a frame, byte reads are issued on consecutive cycles at addresses 0, 1, 2 … WIDTH*HEIGHT-1. This means the pixel at row y and column x is read at y*WIDTH + x.
- R4: With default latencies, a pixel appears on the output two cycles after its memory read strobe. Pixel k of a frame is valid in the (3+k)-th cycle after the clock edge that accepts the start request.
- R5: The start-of-row marker is high exactly on pixels whose column is 0. The end-of-frame marker is high only on the last pixel of the frame. Neither marker is ever high without pixel valid.
- R6: The completion pulse is high for exactly one cycle, in the cycle right after the last pixel of the frame.
- R7: The interrupt flag sets in the cycle after the completion pulse if the vsync enable is high at that pulse. It stays set until the clear input is high. When set and clear occur in the same cycle, set wins. With the enable low, the flag does not change.
- R8: A start request is accepted only while busy is low. Busy is high from the cycle after acceptance through the completion pulse. A start request while busy has no effect: no extra reads and no extra pixels.
- R9: After reset, or after any palette-write pulse, the next frame to start shows the full-update flag high for its whole duration. A frame that starts with no palette write since the previous start shows it low. A palette write in the same cycle as an accepted start applies to the frame after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to scan one frame |
| busy_o | output | 1 | Frame in progress |
| mem_rd_o | output | 1 | Video memory read strobe |
| mem_addr_o | output | AW | Video memory byte address |
| mem_data_i | input | 8 | Byte returned one cycle after read |
| pal_rd_o | output | 1 | Palette read strobe |
| pal_idx_o | output | 8 | Palette entry index |
| pal_r_i | input | 8 | Red component, one cycle after read |
| pal_g_i | input | 8 | Green component |
| pal_b_i | input | 8 | Blue component |
| pix_vld_o | output | 1 | Pixel word valid |
| pix_o | output | 32 | Packed pixel, top byte zero |
| pix_sol_o | output | 1 | First pixel of a row |
| pix_eof_o | output | 1 | Last pixel of the frame |
| frame_done_o | output | 1 | One-cycle frame completion pulse |
| pal_wr_i | input | 1 | Palette has been changed |
| full_o | output | 1 | Current frame needs a full redraw |
| vsync_en_i | input | 1 | Vsync interrupt enable |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| irq_o | output | 1 | Sticky vsync interrupt flag |

## Verification
The main path is driven with three memory images: an index ramp, an all-255 frame, and a scrambled pattern. The ramp shows whether addresses come out in the right order. The all-255 frame exercises the top palette entry. The scrambled pattern separates a true lookup from any fixed relation between address and index. The palette is filled with three unrelated functions of the index, so a swapped or shifted colour field shows up as a wrong word. Further scenarios cover a start pulse in the middle of a frame, palette writes between frames and at the start cycle, and a clear of the interrupt flag that lands on the completion pulse.

// File: rtl/ics_pkg.sv
package ics_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  typedef struct packed {
    logic vld;
    logic sol;
    logic eof;
  } px_tag_t;

  localparam int IDX_W = 8;
  localparam int CH_W  = 8;
endpackage

// File: rtl/ics_scan_ctrl.sv
module ics_scan_ctrl
  import ics_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int HEIGHT = 8,
  parameter int AW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  output logic          run_o,
  output logic          rd_o,
  output logic [AW-1:0] addr_o,
  output px_tag_t       tag_o
);
  localparam int XW = (WIDTH  > 1) ? $clog2(WIDTH)  : 1;
  localparam int YW = (HEIGHT > 1) ? $clog2(HEIGHT) : 1;
  localparam logic [XW-1:0] X_LAST = XW'(WIDTH - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(HEIGHT - 1);

  scan_state_e   state_q, state_d;
  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          row_end, frame_end;

  assign row_end   = (x_q == X_LAST);
  assign frame_end = row_end && (y_q == Y_LAST);

  always_comb begin
    state_d = state_q;
    x_d     = x_q;
    y_d     = y_q;
    addr_d  = addr_q;
    case (state_q)
      SCAN_IDLE: begin
        if (accept_i) begin
          state_d = SCAN_RUN;
          x_d     = '0;
          y_d     = '0;
          addr_d  = '0;
        end
      end
      SCAN_RUN: begin
        addr_d = addr_q + 1'b1;
        if (row_end) begin
          x_d = '0;
          if (frame_end) begin
            state_d = SCAN_IDLE;
          end else begin
            y_d = y_q + 1'b1;
          end
        end else begin
          x_d = x_q + 1'b1;
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      x_q     <= x_d;
      y_q     <= y_d;
      addr_q  <= addr_d;
    end
  end

  assign run_o     = (state_q == SCAN_RUN);
  assign rd_o      = run_o;
  assign addr_o    = addr_q;
  assign tag_o.vld = run_o;
  assign tag_o.sol = run_o && (x_q == '0);
  assign tag_o.eof = run_o && frame_end;
endmodule

// File: rtl/ics_tag_pipe.sv
module ics_tag_pipe
  import ics_pkg::*;
#(
  parameter int DEPTH = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  px_tag_t tag_i,
  output px_tag_t tag_o,
  output logic    any_vld_o
);
  px_tag_t [DEPTH-1:0] stage_q, stage_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb stage_d = tag_i;
    end else begin : g_chain
      always_comb stage_d = {stage_q[DEPTH-2:0], tag_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  always_comb begin
    any_vld_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      any_vld_o = any_vld_o | stage_q[i].vld;
    end
  end

  assign tag_o = stage_q[DEPTH-1];
endmodule

// File: rtl/ics_frame_events.sv
module ics_frame_events (
  input  logic clk,
  input  logic rst_n,
  input  logic last_px_i,
  input  logic accept_i,
  input  logic pal_wr_i,
  input  logic vsync_en_i,
  input  logic irq_clr_i,
  output logic done_o,
  output logic irq_o,
  output logic full_o
);
  logic done_q, done_d;
  logic irq_q, irq_d;
  logic pend_q, pend_d;
  logic full_q, full_d;

  always_comb begin
    done_d = last_px_i;

    irq_d = irq_q;
    if (irq_clr_i) irq_d = 1'b0;
    if (done_q && vsync_en_i) irq_d = 1'b1;

    pend_d = pend_q;
    full_d = full_q;
    if (accept_i) begin
      full_d = pend_q;
      pend_d = pal_wr_i;
    end else if (pal_wr_i) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      pend_q <= 1'b1;
      full_q <= 1'b0;
    end else begin
      done_q <= done_d;
      irq_q  <= irq_d;
      pend_q <= pend_d;
      full_q <= full_d;
    end
  end

  assign done_o = done_q;
  assign irq_o  = irq_q;
  assign full_o = full_q;
endmodule

// File: rtl/ics_scanout.sv
module ics_scanout
  import ics_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int HEIGHT  = 8,
  parameter int MEM_LAT = 1,
  parameter int PAL_LAT = 1,
  parameter int AW      = $clog2(WIDTH * HEIGHT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  output logic          pal_rd_o,
  output logic [7:0]    pal_idx_o,
  input  logic [7:0]    pal_r_i,
  input  logic [7:0]    pal_g_i,
  input  logic [7:0]    pal_b_i,
  output logic          pix_vld_o,
  output logic [31:0]   pix_o,
  output logic          pix_sol_o,
  output logic          pix_eof_o,
  output logic          frame_done_o,
  input  logic          pal_wr_i,
  output logic          full_o,
  input  logic          vsync_en_i,
  input  logic          irq_clr_i,
  output logic          irq_o
);
  px_tag_t issue_tag, mem_tag, pal_tag;
  logic    run, mem_busy, pal_busy, accept, done;

  assign busy_o = run | mem_busy | pal_busy | done;
  assign accept = start_i & ~busy_o;

  ics_scan_ctrl #(.WIDTH(WIDTH), .HEIGHT(HEIGHT), .AW(AW)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .run_o    (run),
    .rd_o     (mem_rd_o),
    .addr_o   (mem_addr_o),
    .tag_o    (issue_tag)
  );

  ics_tag_pipe #(.DEPTH(MEM_LAT)) u_mem_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .tag_i     (issue_tag),
    .tag_o     (mem_tag),
    .any_vld_o (mem_busy)
  );

  assign pal_rd_o  = mem_tag.vld;
  assign pal_idx_o = mem_data_i;

  ics_tag_pipe #(.DEPTH(PAL_LAT)) u_pal_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .tag_i     (mem_tag),
    .tag_o     (pal_tag),
    .any_vld_o (pal_busy)
  );

  assign pix_vld_o = pal_tag.vld;
  assign pix_sol_o = pal_tag.sol;
  assign pix_eof_o = pal_tag.eof;
  assign pix_o     = pal_tag.vld ? {8'h00, pal_r_i, pal_g_i, pal_b_i} : 32'h0;

  ics_frame_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .last_px_i  (pal_tag.vld & pal_tag.eof),
    .accept_i   (accept),
    .pal_wr_i   (pal_wr_i),
    .vsync_en_i (vsync_en_i),
    .irq_clr_i  (irq_clr_i),
    .done_o     (done),
    .irq_o      (irq_o),
    .full_o     (full_o)
  );

  assign frame_done_o = done;
endmodule

// File: rtl/ics_scanout_chk.sv
module ics_scanout_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          pal_rd_o,
  input logic          pix_vld_o,
  input logic [31:0]   pix_o,
  input logic          pix_sol_o,
  input logic          pix_eof_o,
  input logic          frame_done_o,
  input logic          vsync_en_i,
  input logic          irq_o
);
  p_pal_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> pal_rd_o);

  p_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |-> (pix_o[31:24] == 8'h00));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !$past(mem_rd_o)) |-> (mem_addr_o == '0));

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> ##2 pix_vld_o);

  p_marker_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_sol_o || pix_eof_o) |-> pix_vld_o);

  p_done_after_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_o && pix_eof_o) |=> frame_done_o);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_o && vsync_en_i) |=> irq_o);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd_o && !pix_vld_o));
endmodule

bind ics_scanout ics_scanout_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .mem_rd_o     (mem_rd_o),
  .mem_addr_o   (mem_addr_o),
  .pal_rd_o     (pal_rd_o),
  .pix_vld_o    (pix_vld_o),
  .pix_o        (pix_o),
  .pix_sol_o    (pix_sol_o),
  .pix_eof_o    (pix_eof_o),
  .frame_done_o (frame_done_o),
  .vsync_en_i   (vsync_en_i),
  .irq_o        (irq_o)
);

// File: tb/ics_scanout_tb.sv
module ics_scanout_tb;
  localparam int W  = 16;
  localparam int H  = 8;
  localparam int N  = W * H;
  localparam int AW = $clog2(N);

  logic          clk, rst_n, start_i, busy_o, mem_rd_o, pal_rd_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_data_i, pal_idx_o, pal_r_i, pal_g_i, pal_b_i;
  logic          pix_vld_o, pix_sol_o, pix_eof_o, frame_done_o;
  logic [31:0]   pix_o;
  logic          pal_wr_i, full_o, vsync_en_i, irq_clr_i, irq_o;

  logic [7:0] vmem [N];
  logic [7:0] pr [256];
  logic [7:0] pg [256];
  logic [7:0] pb [256];

  int n_chk, n_bad;
  bit done_flag;

  ics_scanout #(.WIDTH(W), .HEIGHT(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .pal_rd_o(pal_rd_o), .pal_idx_o(pal_idx_o),
    .pal_r_i(pal_r_i), .pal_g_i(pal_g_i), .pal_b_i(pal_b_i),
    .pix_vld_o(pix_vld_o), .pix_o(pix_o), .pix_sol_o(pix_sol_o),
    .pix_eof_o(pix_eof_o), .frame_done_o(frame_done_o),
    .pal_wr_i(pal_wr_i), .full_o(full_o), .vsync_en_i(vsync_en_i),
    .irq_clr_i(irq_clr_i), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_o) mem_data_i <= vmem[mem_addr_o];
    if (pal_rd_o) begin
      pal_r_i <= pr[pal_idx_o];
      pal_g_i <= pg[pal_idx_o];
      pal_b_i <= pb[pal_idx_o];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_palette(input int salt);
    for (int i = 0; i < 256; i++) begin
      pr[i] = 8'((i * 7 + salt) & 255);
      pg[i] = 8'(i ^ 8'hA5 ^ salt);
      pb[i] = 8'(255 - i);
    end
  endtask

  function automatic logic [31:0] exp_pix(input int k);
    logic [7:0] ix;
    ix = vmem[k];
    return {8'h00, pr[ix], pg[ix], pb[ix]};
  endfunction

  // Scans one frame and checks addresses, pixels, markers, timing and events.
  task automatic run_frame(input bit exp_full, input bit extra_start,
                           input bit clr_at_done);
    int  k, a, it, last_it, done_it;
    bit  word_ok, sol_ok, eof_ok, addr_ok, lat_ok, top_ok;
    word_ok = 1; sol_ok = 1; eof_ok = 1; addr_ok = 1; lat_ok = 1; top_ok = 1;
    k = 0; a = 0; last_it = -1; done_it = -1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    it = 1;
    chk(busy_o == 1'b1, "R8 busy after accept", 32'(busy_o), 32'd1);
    while (it < N + 20) begin
      if (extra_start && it == 5) start_i = 1'b1;
      if (extra_start && it == 6) start_i = 1'b0;
      if (mem_rd_o) begin
        if (mem_addr_o != AW'(a)) addr_ok = 0;
        a++;
      end
      if (pix_vld_o) begin
        if (k == 0) begin
          chk(full_o == exp_full, "R9 full-update flag", 32'(full_o), 32'(exp_full));
        end
        if (it != 3 + k) lat_ok = 0;
        if (pix_o != exp_pix(k)) begin
          word_ok = 0;
          $display("  pixel %0d got %h want %h", k, pix_o, exp_pix(k));
        end
        if (pix_o[31:24] != 8'h00) top_ok = 0;
        if (pix_sol_o != ((k % W) == 0)) sol_ok = 0;
        if (pix_eof_o != (k == N - 1)) eof_ok = 0;
        if (pix_eof_o) last_it = it;
        k++;
      end else if (pix_sol_o || pix_eof_o) begin
        sol_ok = 0;
      end
      if (frame_done_o) begin
        if (done_it >= 0) done_it = -2; else done_it = it;
        if (clr_at_done) irq_clr_i = 1'b1;
      end else if (clr_at_done) begin
        irq_clr_i = 1'b0;
      end
      @(negedge clk);
      it++;
    end
    irq_clr_i = 1'b0;
    chk(addr_ok && a == N, "R3 row-major read addresses", 32'(a), 32'(N));
    chk(word_ok, "R1 R2 palette lookup of each byte", 32'(k), 32'(N));
    chk(top_ok, "R2 top byte zero", 32'(top_ok), 32'd1);
    chk(lat_ok, "R4 pixel k at cycle 3+k", 32'(lat_ok), 32'd1);
    chk(sol_ok && eof_ok, "R5 row and frame markers", {sol_ok, eof_ok}, 32'd3);
    chk(done_it == last_it + 1 && last_it > 0, "R6 single completion pulse after last pixel",
        32'(done_it), 32'(last_it + 1));
    chk(busy_o == 1'b0 && k == N, "R8 idle after frame, no extra pixels", 32'(k), 32'(N));
  endtask

  task automatic t_reset;
    chk(busy_o == 0 && mem_rd_o == 0 && pix_vld_o == 0, "R8 reset idle",
        {busy_o, mem_rd_o, pix_vld_o}, 32'd0);
    chk(irq_o == 0 && frame_done_o == 0, "R7 reset irq low", {irq_o, frame_done_o}, 32'd0);
  endtask

  task automatic t_ramp;
    for (int i = 0; i < N; i++) vmem[i] = 8'(i);
    vsync_en_i = 1'b1;
    run_frame(1'b1, 1'b0, 1'b0);
    chk(irq_o == 1'b1, "R7 irq set by frame end", 32'(irq_o), 32'd1);
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
    chk(irq_o == 1'b0, "R7 irq cleared", 32'(irq_o), 32'd0);
  endtask

  task automatic t_all_max;
    for (int i = 0; i < N; i++) vmem[i] = 8'hFF;
    vsync_en_i = 1'b0;
    run_frame(1'b0, 1'b0, 1'b0);
    chk(irq_o == 1'b0, "R7 irq untouched with enable low", 32'(irq_o), 32'd0);
  endtask

  task automatic t_scramble_palwr;
    for (int i = 0; i < N; i++) vmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    fill_palette(9);
    @(negedge clk); pal_wr_i = 1'b1;
    @(negedge clk); pal_wr_i = 1'b0;
    run_frame(1'b1, 1'b1, 1'b0);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk(mem_rd_o == 0 && pix_vld_o == 0, "R8 start while busy ignored",
          {mem_rd_o, pix_vld_o}, 32'd0);
    end
  endtask

  task automatic t_palwr_at_start;
    vsync_en_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1; pal_wr_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; pal_wr_i = 1'b0;
    chk(full_o == 1'b0, "R9 write at start does not mark this frame", 32'(full_o), 32'd0);
    while (busy_o) @(negedge clk);
    run_frame(1'b1, 1'b0, 1'b1);
    chk(irq_o == 1'b1, "R7 set wins over clear", 32'(irq_o), 32'd1);
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
    vsync_en_i = 1'b0;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done_flag && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done_flag = 0;
    rst_n = 1'b0; start_i = 1'b0; pal_wr_i = 1'b0; vsync_en_i = 1'b0;
    irq_clr_i = 1'b0; mem_data_i = 8'h00;
    pal_r_i = 8'h00; pal_g_i = 8'h00; pal_b_i = 8'h00;
    fill_palette(3);
    for (int i = 0; i < N; i++) vmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ramp();
    t_all_max();
    t_scramble_palwr();
    t_palwr_at_start();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule